// File: doc/BRIEF.md
# Frame Buffer Fetch Address Generator

This block produces the read addresses that pull frame buffer contents from memory for a display pixel unpacker. Software programs a bank field, a first and a last halfword address, the number of halfwords in one visible line, and a number of halfwords to skip after each line. A frame-start pulse from the display timing generator latches that set of values and restarts the walk at the first address. One 32-bit word (two halfwords) is requested per accepted transfer.

At the end of each visible line the skip count is added on top of the normal step. A narrow window can therefore be shown out of a wider virtual screen. When the walk reaches the last address it returns to the first address and stops requesting until the next frame start. The request is held with a steady address until the memory port grants it.

Top module: `fb_fetch_addr_gen`

## Requirements
- R1: While `rst_ni` is low, `req_o` is 0 and `addr_o` is 0.
- R2: In the cycle after `frame_start_i`, `addr_o` equals {`bank_i`, `start_i`, 1'b0} as sampled with the pulse. `req_o` is 1 exactly when `start_i` < `end_i`.
- R3: An accepted request (`req_o` and `gnt_i`, no frame start) that does not end a line raises the halfword address by 2, which is 4 on `addr_o`.
- R4: A line ends on the accepted request whose line position plus 2 reaches or passes `page_width_i`. The line position counts from 0 at frame start and at each line start. On that request the halfword address rises by 2 plus `skip_i`.
- R5: While `req_o` is 1 and `gnt_i` is 0, `addr_o` and `req_o` hold.
- R6: When the next halfword address would reach or pass `end_i`, the address returns to `start_i` and `req_o` drops. `req_o` then stays 0 until the next frame start.
- R7: Changes on `bank_i`, `start_i`, `end_i`, `page_width_i` and `skip_i` between frame starts do not affect the frame in progress.
- R8: A frame start overrides a grant in the same cycle and restarts the frame from R2, even mid-frame.
- R9: `addr_o` is a byte address. Bits 30:22 hold the bank, bits 21:1 hold the halfword address, and bit 0 is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | One-cycle frame start pulse |
| gnt_i | input | 1 | Memory port accepts the current request |
| bank_i | input | 9 | High address bank field |
| start_i | input | 21 | First halfword address of the frame |
| end_i | input | 21 | Halfword address where frame data finishes |
| page_width_i | input | 10 | Halfwords per visible line |
| skip_i | input | 11 | Halfwords skipped after each line |
| req_o | output | 1 | Read request |
| addr_o | output | 31 | Byte read address |

## Verification
Every result is registered, so each output is due one clock edge after the frame start, grant or stall that causes it. This applies to the load of R2, the steps of R3 and R4, and the stop of R6. The bench drives inputs on the falling edge and updates its model with the same inputs. It compares the outputs on the next falling edge, after exactly one rising edge. Checks that inputs are ignored (R7) change the configuration pins mid-frame and watch the bank bits and the address sequence on the following edges.

// File: rtl/fb_fetch_pkg.sv
package fb_fetch_pkg;
  localparam int unsigned STEP_HW = 2;  // halfwords per 32-bit fetch
  typedef enum logic [1:0] {ADV_HOLD, ADV_WORD, ADV_LINE, ADV_LOAD} adv_e;
endpackage

// File: rtl/fb_fetch_cfg_latch.sv
module fb_fetch_cfg_latch #(
  parameter int BANK_W = 9,
  parameter int OFS_W  = 21,
  parameter int PW_W   = 10,
  parameter int SKIP_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [OFS_W-1:0]  start_i,
  input  logic [OFS_W-1:0]  end_i,
  input  logic [PW_W-1:0]   pw_i,
  input  logic [SKIP_W-1:0] skip_i,
  output logic [BANK_W-1:0] bank_o,
  output logic [OFS_W-1:0]  start_o,
  output logic [OFS_W-1:0]  end_o,
  output logic [PW_W-1:0]   pw_o,
  output logic [SKIP_W-1:0] skip_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_o  <= '0;
      start_o <= '0;
      end_o   <= '0;
      pw_o    <= '0;
      skip_o  <= '0;
    end else if (load_i) begin
      bank_o  <= bank_i;
      start_o <= start_i;
      end_o   <= end_i;
      pw_o    <= pw_i;
      skip_o  <= skip_i;
    end
  end
endmodule

// File: rtl/fb_fetch_line_ctr.sv
module fb_fetch_line_ctr #(
  parameter int PW_W = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            step_i,
  input  logic [PW_W-1:0] pw_i,
  output logic            line_end_o
);
  import fb_fetch_pkg::*;
  localparam int CW = PW_W + 1;

  logic [CW-1:0] col_q, col_nxt;

  assign col_nxt    = col_q + CW'(STEP_HW);
  assign line_end_o = col_nxt >= {1'b0, pw_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         col_q <= '0;
    else if (clr_i)      col_q <= '0;
    else if (step_i)     col_q <= line_end_o ? '0 : col_nxt;
  end
endmodule

// File: rtl/fb_fetch_addr_ptr.sv
module fb_fetch_addr_ptr #(
  parameter int OFS_W  = 21,
  parameter int SKIP_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  fb_fetch_pkg::adv_e adv_i,
  input  logic [OFS_W-1:0]  load_start_i,
  input  logic [OFS_W-1:0]  load_end_i,
  input  logic [OFS_W-1:0]  start_q_i,
  input  logic [OFS_W-1:0]  end_q_i,
  input  logic [SKIP_W-1:0] skip_i,
  output logic [OFS_W-1:0]  cur_o,
  output logic              active_o
);
  import fb_fetch_pkg::*;
  localparam int AW = OFS_W + 1;

  logic [AW-1:0] inc, nxt;
  logic          done;

  assign inc  = (adv_i == ADV_LINE) ? AW'(STEP_HW) + AW'(skip_i) : AW'(STEP_HW);
  assign nxt  = {1'b0, cur_o} + inc;
  assign done = nxt >= {1'b0, end_q_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_o    <= '0;
      active_o <= 1'b0;
    end else begin
      unique case (adv_i)
        ADV_LOAD: begin
          cur_o    <= load_start_i;
          active_o <= load_start_i < load_end_i;
        end
        ADV_WORD, ADV_LINE: begin
          if (done) begin
            cur_o    <= start_q_i;  // wrap and park until next frame
            active_o <= 1'b0;
          end else begin
            cur_o    <= nxt[OFS_W-1:0];
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fb_fetch_addr_gen.sv
module fb_fetch_addr_gen #(
  parameter int BANK_W = 9,
  parameter int OFS_W  = 21,
  parameter int PW_W   = 10,
  parameter int SKIP_W = 11,
  localparam int ADDR_W = BANK_W + OFS_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_start_i,
  input  logic              gnt_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [OFS_W-1:0]  start_i,
  input  logic [OFS_W-1:0]  end_i,
  input  logic [PW_W-1:0]   page_width_i,
  input  logic [SKIP_W-1:0] skip_i,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o
);
  import fb_fetch_pkg::*;

  logic [BANK_W-1:0] bank_q;
  logic [OFS_W-1:0]  start_q, end_q, cur;
  logic [PW_W-1:0]   pw_q;
  logic [SKIP_W-1:0] skip_q;
  logic              active, accept, line_end;
  adv_e              adv;

  assign accept = active & gnt_i & ~frame_start_i;

  always_comb begin
    if (frame_start_i) adv = ADV_LOAD;
    else if (accept)   adv = line_end ? ADV_LINE : ADV_WORD;
    else               adv = ADV_HOLD;
  end

  fb_fetch_cfg_latch #(
    .BANK_W(BANK_W), .OFS_W(OFS_W), .PW_W(PW_W), .SKIP_W(SKIP_W)
  ) cfg_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(frame_start_i),
    .bank_i(bank_i), .start_i(start_i), .end_i(end_i),
    .pw_i(page_width_i), .skip_i(skip_i),
    .bank_o(bank_q), .start_o(start_q), .end_o(end_q),
    .pw_o(pw_q), .skip_o(skip_q)
  );

  fb_fetch_line_ctr #(.PW_W(PW_W)) line_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(frame_start_i),
    .step_i(accept), .pw_i(pw_q), .line_end_o(line_end)
  );

  fb_fetch_addr_ptr #(.OFS_W(OFS_W), .SKIP_W(SKIP_W)) ptr_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(adv),
    .load_start_i(start_i), .load_end_i(end_i),
    .start_q_i(start_q), .end_q_i(end_q), .skip_i(skip_q),
    .cur_o(cur), .active_o(active)
  );

  assign req_o  = active;
  assign addr_o = {bank_q, cur, 1'b0};
endmodule

// File: rtl/fb_fetch_addr_gen_chk.sv
module fb_fetch_addr_gen_chk #(
  parameter int BANK_W = 9,
  parameter int OFS_W  = 21,
  localparam int ADDR_W = BANK_W + OFS_W + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              frame_start_i,
  input logic              gnt_i,
  input logic [BANK_W-1:0] bank_i,
  input logic [OFS_W-1:0]  start_i,
  input logic              req_o,
  input logic [ADDR_W-1:0] addr_o
);
  assert_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> addr_o == {$past(bank_i), $past(start_i), 1'b0});

  assert_stall_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !gnt_i && !frame_start_i |=> $stable(addr_o) && req_o);

  assert_stop_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_o && !frame_start_i |=> !req_o);

  assert_bank_fixed_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i |=> $stable(addr_o[ADDR_W-1:OFS_W+1]));

  assert_byte_even_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_o[0] == 1'b0);
endmodule

bind fb_fetch_addr_gen fb_fetch_addr_gen_chk #(.BANK_W(BANK_W), .OFS_W(OFS_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .frame_start_i(frame_start_i), .gnt_i(gnt_i),
  .bank_i(bank_i), .start_i(start_i), .req_o(req_o), .addr_o(addr_o)
);

// File: tb/fb_fetch_addr_gen_tb_top.sv
module fb_fetch_addr_gen_tb_top;
  localparam int BW = 9, OW = 21, PW = 10, SW = 11, AW = BW + OW + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fs = 1'b0, gnt = 1'b0;
  logic [BW-1:0] bank = '0;
  logic [OW-1:0] st = '0, en = '0;
  logic [PW-1:0] pwid = '0;
  logic [SW-1:0] skip = '0;
  logic          req;
  logic [AW-1:0] addr;

  always #4 clk = ~clk;

  fb_fetch_addr_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .frame_start_i(fs), .gnt_i(gnt),
    .bank_i(bank), .start_i(st), .end_i(en), .page_width_i(pwid),
    .skip_i(skip), .req_o(req), .addr_o(addr)
  );

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // model
  logic          m_act;
  logic [OW-1:0] m_cur, m_st, m_en;
  logic [BW-1:0] m_bank;
  int            m_pw, m_skip, m_col;

  function automatic logic [AW-1:0] exp_addr();
    return {m_bank, m_cur, 1'b0};
  endfunction

  task automatic chk(string tag);
    n_run++;
    if (req !== m_act || addr !== exp_addr()) begin
      n_fail++;
      $display("FAIL %s req=%0b addr=%h expected req=%0b addr=%h", tag, req, addr, m_act, exp_addr());
    end
    n_run++;
    if (addr[0] !== 1'b0) begin
      n_fail++;
      $display("FAIL R9 addr bit0=%0b expected 0", addr[0]);
    end
  endtask

  // called at negedge: apply inputs, advance model, wait one edge, check
  task automatic cyc(input logic f, input logic g);
    string tag;
    int nxt;
    fs = f; gnt = g;
    if (f) begin
      tag = m_act ? "R8" : "R2";
      m_bank = bank; m_st = st; m_en = en; m_pw = int'(pwid); m_skip = int'(skip);
      m_cur = st; m_act = (st < en); m_col = 0;
    end else if (m_act && g) begin
      if (m_col + 2 >= m_pw) begin
        nxt = int'(m_cur) + 2 + m_skip; m_col = 0; tag = "R4";
      end else begin
        nxt = int'(m_cur) + 2; m_col += 2; tag = "R3";
      end
      if (nxt >= int'(m_en)) begin
        m_cur = m_st; m_act = 1'b0; tag = "R6";
      end else m_cur = nxt[OW-1:0];
    end else if (m_act) tag = "R5";
    else tag = "R6";
    @(posedge clk); @(negedge clk);
    chk(tag);
  endtask

  task automatic set_cfg(int b, int s, int e, int p, int k);
    bank = BW'(b); st = OW'(s); en = OW'(e); pwid = PW'(p); skip = SW'(k);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d2c3b4a));
    m_act = 0; m_cur = '0; m_bank = '0; m_st = '0; m_en = '0;
    m_pw = 0; m_skip = 0; m_col = 0;
    repeat (3) @(negedge clk);
    chk("R1");
    set_cfg(3, 50, 60, 4, 0);
    @(negedge clk); chk("R1");  // R1: config pins ignored in reset
    rst_n = 1'b1;
    @(negedge clk); chk("R1");

    // R2/R3/R4/R6: bank 5, 3 words per line, skip 4, 3 lines
    set_cfg(5, 100, 130, 6, 4);
    cyc(1, 0);
    for (int i = 0; i < 12; i++) cyc(0, 1);

    // R5: stalls with gaps
    cyc(1, 0);
    for (int i = 0; i < 20; i++) cyc(0, i % 3 == 0);

    // R7: mid-frame config changes ignored
    set_cfg(5, 200, 260, 8, 2);
    cyc(1, 0);
    for (int i = 0; i < 10; i++) begin
      set_cfg(int'($urandom_range(0, 511)), int'($urandom_range(0, 999)), int'($urandom_range(0, 999)),
              int'($urandom_range(0, 20)), int'($urandom_range(0, 30)));
      cyc(0, 1);
      n_run++;
      if (addr[AW-1:OW+1] !== 9'd5) begin
        n_fail++;
        $display("FAIL R7 bank=%0d expected 5", addr[AW-1:OW+1]);
      end
    end

    // R8: restart while active with grant asserted
    set_cfg(9, 40, 400, 5, 0);
    cyc(1, 1);
    for (int i = 0; i < 5; i++) cyc(0, 1);
    set_cfg(10, 1000, 1100, 5, 0);
    cyc(1, 1);
    for (int i = 0; i < 4; i++) cyc(0, 1);

    // R2: empty frame (start == end) never requests
    set_cfg(2, 70, 70, 4, 1);
    cyc(1, 0);
    for (int i = 0; i < 4; i++) cyc(0, 1);

    // R4/R6: odd page width, zero skip, end not on line boundary
    set_cfg(1, 0, 13, 5, 0);
    cyc(1, 0);
    for (int i = 0; i < 10; i++) cyc(0, 1);

    // R6: top of address range
    set_cfg(511, 2097140, 2097151, 4, 3);
    cyc(1, 0);
    for (int i = 0; i < 8; i++) cyc(0, 1);

    // random
    for (int i = 0; i < 6000; i++) begin
      if (i % 150 == 0 || $urandom_range(0, 299) == 0) begin
        int s;
        s = int'($urandom_range(0, 100000));
        set_cfg(int'($urandom_range(0, 511)), s, s + int'($urandom_range(0, 300)),
                int'($urandom_range(0, 40)), int'($urandom_range(0, 60)));
        cyc(1, $urandom_range(0, 1) == 1);
      end else begin
        cyc(0, $urandom_range(0, 9) < 7);
      end
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule